// File: doc/BRIEF.md
# Three-Channel Programmable Timer with Prescalers and Interrupts

This block holds three 8-bit down-counting timers. Each timer is driven by its own prescaler. The prescaler takes one of two source tick streams: a slow tick (`tick_slow_i`) or a fast tick (`tick_fast_i`). Both are single-cycle enables in the system clock domain. The prescaler divides the chosen stream by 1, 4, 32 or 256. On each divided tick the timer decrements. When a tick arrives while the timer sits at zero, the timer reloads from its 8-bit reload register and raises its interrupt flag. The interrupt output of a channel is that flag gated by the channel's enable bit.

Software reaches the block through a 4-bit register bus with a combinational read path. Writes take effect on the next clock edge. Two modes change how the channels are clocked. In event mode, channel 0 counts pulses on `event_i`. In cascade mode, channel 1 counts the underflows of channel 0, so the pair forms one 16-bit timer. In either mode, the source and ratio settings of the channel being overridden have no effect.

Top module: `timer_prescaler_bank`

## Requirements
- R1: Bit 0 of a channel's config register (addresses 0, 1 and 2 for channels 0, 1 and 2) picks the prescaler source: 0 selects `tick_slow_i` and 1 selects `tick_fast_i`. A channel on the slow source never counts while `tick_slow_i` stays low.
- R2: Bits 2:1 of the config register give the division ratio: 00 divides by 1, 01 by 4, 10 by 32 and 11 by 256. With reload value R, consecutive underflows are (R+1) times the ratio source ticks apart.
- R3: When bit 0 of the mode register (address 3) is 1, channel 0 decrements once per cycle in which `event_i` is high, and its config register has no effect.
- R4: When bit 1 of the mode register is 1, channel 1 decrements once per channel-0 underflow, and its config register has no effect.
- R5: After reset, every readable location returns 0. This covers the config, mode, enable and flag registers and all counts.
- R6: The count of channel n reads as its low nibble at address 4+2n and its high nibble at address 5+2n. A write to either address changes only the matching nibble of the reload register and never the running count.
- R7: On each tick, a timer at 0 loads its reload value and sets its flag. Otherwise it decrements by 1.
- R8: The flag register (address 11, bit n for channel n) is cleared bit by bit by writing 1. Writing 0 leaves a flag unchanged.
- R9: If an underflow and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R10: The enable register (address 10, bit n for channel n) gates `irq_o[n]`, which equals flag AND enable. A flag still sets while its channel is masked.
- R11: Unused bits read 0. This applies to bit 3 of the config, enable and flag registers, to bits 3:2 of the mode register, and to every bit at addresses 12 to 15, where writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_slow_i | input | 1 | Slow source tick enable |
| tick_fast_i | input | 1 | Fast source tick enable |
| event_i | input | 1 | External event pulse for channel 0 in event mode |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Read data for `addr_i` (combinational) |
| irq_o | output | 3 | Per-channel interrupt request |

## Verification
Some properties are checked by assertions on every cycle:
- each tick produces exactly one decrement or one reload;
- a ratio above 1 never gives two prescaler ticks in consecutive cycles;
- an idle event input or an idle channel-0 underflow freezes the overridden timer;
- a flag falls only on a flag-register write and always rises on an underflow;
- masked interrupts stay low;
- unused read bits are zero.

Other behaviour can only be shown by the directed scenarios:
- the exact underflow period for each ratio and each source;
- the arithmetic of the 16-bit cascade period;
- the nibble layout of counts and reload values;
- the fact that mode overrides discard the config settings.

// File: rtl/tpb_pkg.sv
package tpb_pkg;
    localparam int NUM_CH = 3;
    localparam int BUS_W  = 4;
    localparam int ADDR_W = 4;
    localparam int CNT_W  = 8;
    localparam int PRE_W  = 8;

    typedef enum logic [1:0] {
        DIV_1   = 2'b00,
        DIV_4   = 2'b01,
        DIV_32  = 2'b10,
        DIV_256 = 2'b11
    } div_e;

    typedef struct packed {
        div_e div;
        logic src_fast;
    } chcfg_t;

    typedef struct packed {
        logic cascade;
        logic event_mode;
    } mode_t;

    localparam logic [ADDR_W-1:0] ADR_CFG0  = 4'h0;
    localparam logic [ADDR_W-1:0] ADR_MODE  = 4'h3;
    localparam logic [ADDR_W-1:0] ADR_DATA0 = 4'h4;
    localparam logic [ADDR_W-1:0] ADR_IEN   = 4'hA;
    localparam logic [ADDR_W-1:0] ADR_IFLG  = 4'hB;

    // Low prescaler bits that must all be ones for a divided tick.
    function automatic logic [PRE_W-1:0] div_mask(div_e d);
        case (d)
            DIV_1:   return '0;
            DIV_4:   return PRE_W'(8'h03);
            DIV_32:  return PRE_W'(8'h1F);
            default: return PRE_W'(8'hFF);
        endcase
    endfunction
endpackage

// File: rtl/tpb_prescaler.sv
module tpb_prescaler
    import tpb_pkg::*;
#(
    parameter int PW = PRE_W
) (
    input  logic clk,
    input  logic rst,
    input  logic src_tick_i,
    input  div_e div_i,
    output logic tick_o
);
    logic [PW-1:0] cnt_q;
    logic [PW-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (src_tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        mask   = PW'(div_mask(div_i));
        tick_o = src_tick_i && ((cnt_q & mask) == mask);
    end

    // After a divided tick the low bits wrap to zero, so no ratio above 1 can tick again at once
    assert_no_back_to_back_R2: assert property (@(posedge clk) disable iff (rst)
        (tick_o && div_i != DIV_1) |=> (!tick_o || div_i == DIV_1));
endmodule

// File: rtl/tpb_downcnt.sv
module tpb_downcnt
    import tpb_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic [CW-1:0] reload_i,
    output logic [CW-1:0] count_o,
    output logic          uflow_o
);
    logic [CW-1:0] cnt_q;

    assign uflow_o = tick_i && (cnt_q == '0);
    assign count_o = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (uflow_o) begin
            cnt_q <= reload_i;
        end else if (tick_i) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_reload_at_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (tick_i && count_o == '0) |=> (count_o == $past(reload_i)));
    assert_step_down_R7: assert property (@(posedge clk) disable iff (rst)
        (tick_i && count_o != '0) |=> (count_o == $past(count_o) - 1'b1));
    assert_hold_without_tick_R7: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(count_o));
endmodule

// File: rtl/tpb_regs.sv
module tpb_regs
    import tpb_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int CW  = CNT_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [BUS_W-1:0]         wdata_i,
    output logic [BUS_W-1:0]         rdata_o,
    input  logic [NCH-1:0]           uflow_i,
    input  logic [NCH-1:0][CW-1:0]   count_i,
    output chcfg_t [NCH-1:0]         cfg_o,
    output mode_t                    mode_o,
    output logic [NCH-1:0][CW-1:0]   reload_o,
    output logic [NCH-1:0]           irq_o
);
    localparam int NIB = CW / BUS_W;
    localparam int CFG_W = $bits(chcfg_t);
    localparam int MODE_W = $bits(mode_t);

    chcfg_t [NCH-1:0]       cfg_q;
    mode_t                  mode_q;
    logic [NCH-1:0][CW-1:0] reload_q;
    logic [NCH-1:0]         ien_q;
    logic [NCH-1:0]         flag_q;
    logic [NCH-1:0]         clr_vec;

    always_comb begin
        clr_vec = (wr_en_i && addr_i == ADR_IFLG) ? wdata_i[NCH-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            mode_q   <= '0;
            reload_q <= '0;
            ien_q    <= '0;
            flag_q   <= '0;
        end else begin
            // an underflow in the same cycle outranks the clear
            flag_q <= (flag_q & ~clr_vec) | uflow_i;
            if (wr_en_i) begin
                for (int n = 0; n < NCH; n++) begin
                    if (addr_i == ADDR_W'(ADR_CFG0 + n)) begin
                        cfg_q[n] <= chcfg_t'(wdata_i[CFG_W-1:0]);
                    end
                    for (int k = 0; k < NIB; k++) begin
                        if (addr_i == ADDR_W'(ADR_DATA0 + NIB * n + k)) begin
                            reload_q[n][k*BUS_W +: BUS_W] <= wdata_i;
                        end
                    end
                end
                if (addr_i == ADR_MODE) begin
                    mode_q <= mode_t'(wdata_i[MODE_W-1:0]);
                end
                if (addr_i == ADR_IEN) begin
                    ien_q <= wdata_i[NCH-1:0];
                end
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int n = 0; n < NCH; n++) begin
            if (addr_i == ADDR_W'(ADR_CFG0 + n)) begin
                rdata_o = BUS_W'(cfg_q[n]);
            end
            for (int k = 0; k < NIB; k++) begin
                if (addr_i == ADDR_W'(ADR_DATA0 + NIB * n + k)) begin
                    rdata_o = count_i[n][k*BUS_W +: BUS_W];
                end
            end
        end
        if (addr_i == ADR_MODE) rdata_o = BUS_W'(mode_q);
        if (addr_i == ADR_IEN)  rdata_o = BUS_W'(ien_q);
        if (addr_i == ADR_IFLG) rdata_o = BUS_W'(flag_q);
    end

    assign cfg_o    = cfg_q;
    assign mode_o   = mode_q;
    assign reload_o = reload_q;
    assign irq_o    = flag_q & ien_q;

    assert_flag_only_w1c_R8: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_i && addr_i == ADR_IFLG) |=> (($past(flag_q) & ~flag_q) == '0));
    assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (|uflow_i) |=> ((flag_q & $past(uflow_i)) == $past(uflow_i)));
    assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (ien_q == '0) |-> (irq_o == '0));
    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (addr_i > ADR_IFLG) |-> (rdata_o == '0));
    assert_spare_bits_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (addr_i == ADR_IEN || addr_i == ADR_IFLG) |-> (rdata_o[BUS_W-1:NCH] == '0));
endmodule

// File: rtl/timer_prescaler_bank.sv
module timer_prescaler_bank
    import tpb_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int CW  = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_slow_i,
    input  logic              tick_fast_i,
    input  logic              event_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [BUS_W-1:0]  rdata_o,
    output logic [NCH-1:0]    irq_o
);
    chcfg_t [NCH-1:0]       cfg;
    mode_t                  mode;
    logic [NCH-1:0][CW-1:0] reload;
    logic [NCH-1:0][CW-1:0] count;
    logic [NCH-1:0]         ps_tick;
    logic [NCH-1:0]         ch_tick;
    logic [NCH-1:0]         uflow;

    tpb_regs #(.NCH(NCH), .CW(CW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en_i  (wr_en_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .rdata_o  (rdata_o),
        .uflow_i  (uflow),
        .count_i  (count),
        .cfg_o    (cfg),
        .mode_o   (mode),
        .reload_o (reload),
        .irq_o    (irq_o)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic src_tick;
        assign src_tick = cfg[n].src_fast ? tick_fast_i : tick_slow_i;

        tpb_prescaler #(.PW(PRE_W)) u_pre (
            .clk        (clk),
            .rst        (rst),
            .src_tick_i (src_tick),
            .div_i      (cfg[n].div),
            .tick_o     (ps_tick[n])
        );

        tpb_downcnt #(.CW(CW)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .tick_i   (ch_tick[n]),
            .reload_i (reload[n]),
            .count_o  (count[n]),
            .uflow_o  (uflow[n])
        );
    end

    // Mode overrides; channel-0 underflow is formed from its registered count to keep the path acyclic
    always_comb begin
        ch_tick = ps_tick;
        if (mode.event_mode) ch_tick[0] = event_i;
        if (mode.cascade)    ch_tick[1] = ch_tick[0] && (count[0] == '0);
    end

    assert_slow_idle_R1: assert property (@(posedge clk) disable iff (rst)
        (!cfg[NCH-1].src_fast && !tick_slow_i) |=> $stable(count[NCH-1]));
    assert_event_gates_ch0_R3: assert property (@(posedge clk) disable iff (rst)
        (mode.event_mode && !event_i) |=> $stable(count[0]));
    assert_cascade_gates_ch1_R4: assert property (@(posedge clk) disable iff (rst)
        (mode.cascade && !uflow[0]) |=> $stable(count[1]));
endmodule

// File: tb/tb_timer_prescaler_bank.sv
module tb_timer_prescaler_bank;
    localparam logic [3:0] A_MODE = 4'h3;
    localparam logic [3:0] A_IEN  = 4'hA;
    localparam logic [3:0] A_IFLG = 4'hB;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_slow = 1'b0;
    logic       tick_fast = 1'b0;
    logic       event_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = 4'h0;
    logic [3:0] wdata = 4'h0;
    logic [3:0] rdata;
    logic [2:0] irq;
    logic       slow_en = 1'b0;
    int         cyc = 0;
    int         total = 0;
    int         failed = 0;
    bit         done = 1'b0;

    timer_prescaler_bank dut (
        .clk         (clk),
        .rst         (rst),
        .tick_slow_i (tick_slow),
        .tick_fast_i (tick_fast),
        .event_i     (event_in),
        .wr_en_i     (wr_en),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .irq_o       (irq)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) tick_slow <= slow_en ? ~tick_slow : 1'b0;

    task automatic check(string req, int act, int exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a negedge; the write lands on the next posedge
    task automatic bus_write(logic [3:0] a, logic [3:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(logic [3:0] a, output logic [3:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic set_reload(int ch, logic [7:0] v);
        bus_write(4'(4 + 2 * ch), v[3:0]);
        bus_write(4'(5 + 2 * ch), v[7:4]);
    endtask

    task automatic read_count(int ch, output logic [7:0] v);
        logic [3:0] lo, hi;
        bus_read(4'(4 + 2 * ch), lo);
        bus_read(4'(5 + 2 * ch), hi);
        v = {hi, lo};
    endtask

    task automatic pulse_events(int n);
        for (int i = 0; i < n; i++) begin
            event_in = 1'b1;
            @(negedge clk);
            event_in = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic wait_flag(int ch, string req);
        logic [3:0] f;
        int polls;
        polls = 0;
        bus_read(A_IFLG, f);
        while (!f[ch] && polls < 4000) begin
            @(negedge clk);
            polls++;
            bus_read(A_IFLG, f);
        end
        if (!f[ch]) check(req, 0, 1);
    endtask

    task automatic measure(int ch, string req, output int p);
        int t0;
        wait_flag(ch, req);
        bus_write(A_IFLG, 4'(1 << ch));
        wait_flag(ch, req);
        t0 = cyc;
        bus_write(A_IFLG, 4'(1 << ch));
        wait_flag(ch, req);
        p = cyc - t0;
    endtask

    task automatic t_reset;
        logic [3:0] d;
        for (int a = 0; a < 16; a++) begin
            bus_read(4'(a), d);
            check("R5 reset read", int'(d), 0);
        end
    endtask

    task automatic t_unused;
        logic [3:0] d;
        bus_write(4'h0, 4'hF);
        bus_read(4'h0, d);
        check("R11 config spare bit", int'(d), 7);
        bus_write(4'h0, 4'h0);
        bus_write(A_IEN, 4'hF);
        bus_read(A_IEN, d);
        check("R11 enable spare bit", int'(d), 7);
        bus_write(A_IEN, 4'h0);
        bus_write(A_MODE, 4'hC);
        bus_read(A_MODE, d);
        check("R11 mode spare bits", int'(d), 0);
        for (int a = 12; a < 16; a++) begin
            bus_write(4'(a), 4'hF);
            bus_read(4'(a), d);
            check("R11 unmapped address", int'(d), 0);
        end
    endtask

    task automatic t_ratio;
        int p;
        tick_fast = 1'b1;
        set_reload(2, 8'h03);
        for (int d = 0; d < 4; d++) begin
            bus_write(4'h2, 4'((d << 1) | 1));
            measure(2, "R2 ratio period", p);
            check("R2 ratio period", p, 4 * (d == 0 ? 1 : d == 1 ? 4 : d == 2 ? 32 : 256));
        end
        bus_write(4'h2, 4'h1);
        set_reload(2, 8'h12);
        measure(2, "R7 reload period", p);
        check("R7 reload 0x12 period", p, 19);
        bus_write(4'h2, 4'h0);
    endtask

    task automatic t_slow;
        int p;
        slow_en = 1'b1;
        set_reload(1, 8'h02);
        bus_write(4'h1, 4'h2);
        measure(1, "R1 slow source", p);
        check("R1 slow source /4", p, 24);
        bus_write(4'h1, 4'h3);
        measure(1, "R1 fast source", p);
        check("R1 fast source /4", p, 12);
        bus_write(4'h1, 4'h0);
        slow_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_event_count;
        logic [7:0] c, v;
        bus_write(A_MODE, 4'h1);
        read_count(0, c);
        bus_write(4'h0, 4'h1);
        repeat (20) @(negedge clk);
        read_count(0, v);
        check("R3 config ignored in event mode", int'(v), int'(c));
        set_reload(0, 8'hA5);
        pulse_events(int'(c) + 1);
        read_count(0, v);
        check("R6 low nibble", int'(v[3:0]), 5);
        check("R6 high nibble", int'(v[7:4]), 10);
        pulse_events(1);
        read_count(0, v);
        check("R3 one event one step", int'(v), 8'hA4);
        bus_write(4'h4, 4'h3);
        read_count(0, v);
        check("R6 write leaves count", int'(v), 8'hA4);
        pulse_events(8'hA5);
        read_count(0, v);
        check("R6 write reached reload", int'(v), 8'hA3);
    endtask

    task automatic t_flags;
        logic [3:0] f;
        set_reload(0, 8'h00);
        pulse_events(8'hA4);
        bus_write(A_IFLG, 4'h7);
        bus_read(A_IFLG, f);
        check("R8 all cleared", int'(f), 0);
        pulse_events(1);
        bus_read(A_IFLG, f);
        check("R10 flag sets while masked", int'(f), 1);
        check("R10 masked irq", int'(irq), 0);
        bus_write(A_IFLG, 4'h0);
        bus_read(A_IFLG, f);
        check("R8 write 0 keeps flag", int'(f), 1);
        bus_write(A_IEN, 4'h1);
        check("R10 enabled irq", int'(irq), 1);
        bus_write(A_IFLG, 4'h1);
        bus_read(A_IFLG, f);
        check("R8 write 1 clears", int'(f), 0);
        check("R10 irq drops", int'(irq), 0);
        wr_en = 1'b1; addr = A_IFLG; wdata = 4'h1; event_in = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; event_in = 1'b0;
        bus_read(A_IFLG, f);
        check("R9 set wins over clear", int'(f), 1);
        bus_write(A_IFLG, 4'h7);
        bus_write(A_IEN, 4'h0);
    endtask

    task automatic t_cascade;
        int p;
        bus_write(A_MODE, 4'h2);
        bus_write(4'h0, 4'h1);
        set_reload(0, 8'h03);
        bus_write(4'h1, 4'h1);
        set_reload(1, 8'h02);
        measure(0, "R4 low half", p);
        check("R4 low half period", p, 4);
        measure(1, "R4 cascade", p);
        check("R4 cascade period", p, 12);
        bus_write(4'h1, 4'h6);
        measure(1, "R4 config ignored", p);
        check("R4 ch1 config ignored", p, 12);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_unused();
        t_ratio();
        t_slow();
        t_event_count();
        t_flags();
        t_cascade();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            failed++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end
endmodule